// File: doc/BRIEF.md
# Tiled Crosspoint Fabric Controller

This block builds one large switch fabric out of a grid of 8x8 crosspoint slices. Each slice holds two ranks of per-output routing entries. The grid has `N_COL` input groups and `N_ROW` output groups. Input group `c` feeds the same eight fabric inputs to every slice in column `c`, which is how the number of outputs grows. The slices in row `r` merge their outputs onto eight shared buses, which are fabric outputs `8r` to `8r+7`, and this is how the number of inputs grows.

A host issues one routing request per cycle. Each request carries a global source index, a global destination index and an enable bit. The controller turns the request into a row chip select and local input and output addresses on buses that every slice shares. It also drives one disable line per column. Every slice in the addressed row is written in the same cycle, and only the slice whose column holds the chosen source is written as enabled. A separate commit strobe reaches every slice in the same cycle, so the whole fabric changes its routing on one edge.

A clear strobe sets both ranks of every slice at once. It has two modes: route every output to global source 0, or turn every output off. Each shared bus is modelled as the OR of its enabled drivers, and a checker raises a per-bus flag when more than one driver is enabled.

Top module: `xp_fabric_ctrl`

## Requirements
- R1: After the asynchronous reset, every output is undriven: `drive_o` is all zero, `data_o` is all zero and `contend_o` is all zero.
- R2: The source index splits into an upper column field and a lower 3-bit local input. The destination index splits into an upper row field and a lower 3-bit local output. After a request (`src`, `dst`, enable 1) and a later commit, `data_o[dst]` follows `data_i[src]` and `drive_o[dst]` is 1.
- R3: A request alone changes no output. A commit that falls in the same cycle as a request installs the entries loaded before that request. The new request waits in the first rank for the next commit.
- R4: A request leaves at most one enabled driver on the addressed bus, even when the destination moves from one column to another, so `contend_o` stays zero.
- R5: A request with enable 0 disables its destination in every column. After the commit, that destination has `drive_o` at 0 and `data_o` at 0.
- R6: A request whose column field is `N_COL` or larger is written as disabled in every column. After the commit, the destination is undriven.
- R7: A request writes only the slices of the addressed row. Outputs with the same local index in other rows keep their routing.
- R8: The clear strobe updates both ranks on its own edge, with no commit, and it takes priority over a request or commit in the same cycle. With `clear_off_i` at 0, every output follows `data_i[0]` and is driven. With `clear_off_i` at 1, every output is undriven.
- R9: Each shared bus reads as the OR of its enabled drivers. A bus with no enabled driver reads 0.
- R10: One commit installs every pending request, across all rows, on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Routing request strobe, one cycle per request |
| req_src_i | input | SRC_W (5) | Global source index |
| req_dst_i | input | DST_W (5) | Global destination index |
| req_en_i | input | 1 | 1 connects the destination, 0 disables it |
| commit_i | input | 1 | Fabric-wide commit of the first rank into the second |
| clear_i | input | 1 | Clear both ranks in every slice |
| clear_off_i | input | 1 | Clear mode: 0 routes all outputs to source 0, 1 turns all outputs off |
| data_i | input | N_COL*8 (24) | Fabric input data |
| data_o | output | N_ROW*8 (32) | Shared output buses |
| drive_o | output | N_ROW*8 (32) | Bus has an enabled driver |
| contend_o | output | N_ROW*8 (32) | Bus has more than one enabled driver |

## Verification
The assertions assume that the strobes and index fields are known, two-valued and held for whole cycles. They also assume that a slice is written only through the request port, because the no-contention property depends on each request reaching every column of its row. `clear_off_i` is read only in a cycle where `clear_i` is high. The stimulus changes every input on the falling clock edge and raises each strobe for exactly one cycle. The only request traffic is host requests of the documented form, including column fields past the last group and requests that overlap a commit or a clear.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int LANES  = 8;
  localparam int LIDX_W = 3;

  typedef struct packed {
    logic              off;
    logic [LIDX_W-1:0] src;
  } xp_entry_t;
endpackage

// File: rtl/xp_slice.sv
module xp_slice
  import xp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [LIDX_W-1:0] in_idx_i,
  input  logic [LIDX_W-1:0] out_idx_i,
  input  logic              off_i,
  input  logic              cfg_i,
  input  logic              clr_i,
  input  logic              clr_off_i,
  input  logic [LANES-1:0]  din_i,
  output logic [LANES-1:0]  dout_o,
  output logic [LANES-1:0]  den_o
);
  xp_entry_t [LANES-1:0] ld_q;
  xp_entry_t [LANES-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LANES; k++) begin
        ld_q[k]  <= '{off: 1'b1, src: '0};
        cfg_q[k] <= '{off: 1'b1, src: '0};
      end
    end else if (clr_i) begin
      for (int k = 0; k < LANES; k++) begin
        ld_q[k]  <= '{off: clr_off_i, src: '0};
        cfg_q[k] <= '{off: clr_off_i, src: '0};
      end
    end else begin
      if (cfg_i) cfg_q <= ld_q;
      if (cs_i)  ld_q[out_idx_i] <= '{off: off_i, src: in_idx_i};
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      den_o[k]  = !cfg_q[k].off;
      dout_o[k] = cfg_q[k].off ? 1'b0 : din_i[cfg_q[k].src];
    end
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i && !clr_i) |=> $stable(cfg_q));
endmodule

// File: rtl/xp_decode.sv
module xp_decode
  import xp_pkg::*;
#(
  parameter int N_COL  = 3,
  parameter int N_ROW  = 4,
  parameter int COLF_W = 2,
  parameter int ROWF_W = 2,
  localparam int SRC_W = COLF_W + LIDX_W,
  localparam int DST_W = ROWF_W + LIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic              en_i,
  input  logic              clr_mode_off_i,
  output logic [N_ROW-1:0]  row_cs_o,
  output logic [N_COL-1:0]  col_off_o,
  output logic [N_COL-1:0]  clr_off_o,
  output logic [LIDX_W-1:0] loc_in_o,
  output logic [LIDX_W-1:0] loc_out_o
);
  logic [COLF_W-1:0] src_col;
  logic [ROWF_W-1:0] dst_row;
  logic              col_ok;

  assign src_col   = src_i[SRC_W-1:LIDX_W];
  assign dst_row   = dst_i[DST_W-1:LIDX_W];
  assign loc_in_o  = src_i[LIDX_W-1:0];
  assign loc_out_o = dst_i[LIDX_W-1:0];
  assign col_ok    = 32'(src_col) < N_COL;

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    assign row_cs_o[r] = wr_i && (32'(dst_row) == r);
  end

  // unselected columns are written disabled so one slice owns each bus
  for (genvar c = 0; c < N_COL; c++) begin : g_col
    assign col_off_o[c] = !en_i || !col_ok || (32'(src_col) != c);
    // broadcast clear: only column 0 stays on, keeping the bus single-driver
    assign clr_off_o[c] = clr_mode_off_i || (c != 0);
  end

  // R4
  one_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> $onehot0(~col_off_o));

  // R6
  oor_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (32'(src_col) >= N_COL)) |-> (&col_off_o));
endmodule

// File: rtl/xp_bus_merge.sv
module xp_bus_merge #(
  parameter int N_DRV = 3,
  parameter int LANES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_DRV*LANES-1:0] dat_i,
  input  logic [N_DRV*LANES-1:0] en_i,
  output logic [LANES-1:0]       bus_o,
  output logic [LANES-1:0]       drv_o,
  output logic [LANES-1:0]       contend_o
);
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bus_o[l]     = 1'b0;
      drv_o[l]     = 1'b0;
      contend_o[l] = 1'b0;
      for (int d = 0; d < N_DRV; d++) begin
        if (en_i[d*LANES+l]) begin
          contend_o[l] = contend_o[l] | drv_o[l];
          drv_o[l]     = 1'b1;
          bus_o[l]     = bus_o[l] | dat_i[d*LANES+l];
        end
      end
    end
  end

  // R4
  no_contend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contend_o == '0);
endmodule

// File: rtl/xp_fabric_ctrl.sv
module xp_fabric_ctrl
  import xp_pkg::*;
#(
  parameter int N_COL = 3,
  parameter int N_ROW = 4,
  localparam int COLF_W = (N_COL > 1) ? $clog2(N_COL) : 1,
  localparam int ROWF_W = (N_ROW > 1) ? $clog2(N_ROW) : 1,
  localparam int SRC_W  = COLF_W + LIDX_W,
  localparam int DST_W  = ROWF_W + LIDX_W,
  localparam int N_IN   = N_COL * LANES,
  localparam int N_OUT  = N_ROW * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic [DST_W-1:0] req_dst_i,
  input  logic             req_en_i,
  input  logic             commit_i,
  input  logic             clear_i,
  input  logic             clear_off_i,
  input  logic [N_IN-1:0]  data_i,
  output logic [N_OUT-1:0] data_o,
  output logic [N_OUT-1:0] drive_o,
  output logic [N_OUT-1:0] contend_o
);
  logic [N_ROW-1:0]  row_cs;
  logic [N_COL-1:0]  col_off;
  logic [N_COL-1:0]  clr_off;
  logic [LIDX_W-1:0] loc_in;
  logic [LIDX_W-1:0] loc_out;

  xp_decode #(
    .N_COL (N_COL),
    .N_ROW (N_ROW),
    .COLF_W(COLF_W),
    .ROWF_W(ROWF_W)
  ) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (req_valid_i),
    .src_i         (req_src_i),
    .dst_i         (req_dst_i),
    .en_i          (req_en_i),
    .clr_mode_off_i(clear_off_i),
    .row_cs_o      (row_cs),
    .col_off_o     (col_off),
    .clr_off_o     (clr_off),
    .loc_in_o      (loc_in),
    .loc_out_o     (loc_out)
  );

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    logic [N_COL*LANES-1:0] r_dat;
    logic [N_COL*LANES-1:0] r_en;

    for (genvar c = 0; c < N_COL; c++) begin : g_col
      xp_slice u_slice (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_i     (row_cs[r]),
        .in_idx_i (loc_in),
        .out_idx_i(loc_out),
        .off_i    (col_off[c]),
        .cfg_i    (commit_i),
        .clr_i    (clear_i),
        .clr_off_i(clr_off[c]),
        .din_i    (data_i[c*LANES +: LANES]),
        .dout_o   (r_dat[c*LANES +: LANES]),
        .den_o    (r_en[c*LANES +: LANES])
      );
    end

    xp_bus_merge #(
      .N_DRV(N_COL),
      .LANES(LANES)
    ) u_merge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dat_i    (r_dat),
      .en_i     (r_en),
      .bus_o    (data_o[r*LANES +: LANES]),
      .drv_o    (drive_o[r*LANES +: LANES]),
      .contend_o(contend_o[r*LANES +: LANES])
    );
  end

  // R8
  bcast_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !clear_off_i) |=> (&drive_o));

  // R8
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && clear_off_i) |=> (drive_o == '0));
endmodule

// File: tb/xp_fabric_ctrl_test.sv
module xp_fabric_ctrl_test;
  localparam int N_IN  = 24;
  localparam int N_OUT = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 1'b0;
  logic [4:0]        req_src = '0;
  logic [4:0]        req_dst = '0;
  logic              req_en = 1'b0;
  logic              commit = 1'b0;
  logic              clear = 1'b0;
  logic              clear_off = 1'b0;
  logic [N_IN-1:0]   data_in = '0;
  logic [N_OUT-1:0]  data_out, drive, contend;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic       pend_on [N_OUT];
  logic [4:0] pend_src[N_OUT];
  logic       live_on [N_OUT];
  logic [4:0] live_src[N_OUT];

  always #4 clk = ~clk;

  xp_fabric_ctrl uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid),
    .req_src_i  (req_src),
    .req_dst_i  (req_dst),
    .req_en_i   (req_en),
    .commit_i   (commit),
    .clear_i    (clear),
    .clear_off_i(clear_off),
    .data_i     (data_in),
    .data_o     (data_out),
    .drive_o    (drive),
    .contend_o  (contend)
  );

  task automatic chk(string req, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N_OUT-1:0] exp_drive();
    logic [N_OUT-1:0] v;
    for (int o = 0; o < N_OUT; o++) v[o] = live_on[o];
    return v;
  endfunction

  function automatic logic [N_OUT-1:0] exp_data();
    logic [N_OUT-1:0] v;
    for (int o = 0; o < N_OUT; o++) v[o] = live_on[o] ? data_in[live_src[o]] : 1'b0;
    return v;
  endfunction

  // compare the whole fabric against the model under two input patterns
  task automatic check_all(string req);
    data_in = 24'h5a3c96;
    #1;
    chk(req, drive, exp_drive());
    chk(req, data_out, exp_data());
    chk({req, " R4 contention"}, contend, '0);
    data_in = ~24'h5a3c96;
    #1;
    chk({req, " R9"}, data_out, exp_data());
  endtask

  task automatic model_write(logic [4:0] s, logic [4:0] d, logic e);
    pend_on[d]  = e && (s < 5'(N_IN));
    pend_src[d] = s;
  endtask

  task automatic model_commit();
    for (int o = 0; o < N_OUT; o++) begin
      live_on[o]  = pend_on[o];
      live_src[o] = pend_src[o];
    end
  endtask

  task automatic model_clear(logic off);
    for (int o = 0; o < N_OUT; o++) begin
      pend_on[o] = !off; pend_src[o] = '0;
      live_on[o] = !off; live_src[o] = '0;
    end
  endtask

  task automatic drive_cycle(logic v, logic [4:0] s, logic [4:0] d, logic e,
                             logic cm, logic cl, logic co);
    @(negedge clk);
    req_valid = v; req_src = s; req_dst = d; req_en = e;
    commit = cm; clear = cl; clear_off = co;
    @(negedge clk);
    req_valid = 1'b0; commit = 1'b0; clear = 1'b0; clear_off = 1'b0;
  endtask

  task automatic write(logic [4:0] s, logic [4:0] d, logic e);
    drive_cycle(1'b1, s, d, e, 1'b0, 1'b0, 1'b0);
    model_write(s, d, e);
  endtask

  task automatic do_commit();
    drive_cycle(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    model_commit();
  endtask

  task automatic t_reset();
    for (int o = 0; o < N_OUT; o++) begin
      pend_on[o] = 1'b0; pend_src[o] = '0; live_on[o] = 1'b0; live_src[o] = '0;
    end
    data_in = '1;
    #1;
    chk("R1 drive", drive, '0);
    chk("R1 data", data_out, '0);
    chk("R1 contend", contend, '0);
  endtask

  task automatic t_route();
    write(5'd5, 5'd0, 1'b1);
    write(5'd13, 5'd9, 1'b1);
    write(5'd22, 5'd31, 1'b1);
    write(5'd0, 5'd17, 1'b1);
    write(5'd8, 5'd20, 1'b1);
    do_commit();
    check_all("R2 route");
  endtask

  task automatic t_buffer();
    write(5'd7, 5'd0, 1'b1);
    check_all("R3 no commit");
    // request and commit together: commit takes the earlier entry only
    drive_cycle(1'b1, 5'd19, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0);
    model_commit();
    model_write(5'd19, 5'd4, 1'b1);
    check_all("R3 same-cycle commit");
    do_commit();
    check_all("R3 later commit");
  endtask

  task automatic t_exclusive();
    write(5'd2, 5'd5, 1'b1);  do_commit(); check_all("R4 col0");
    write(5'd18, 5'd5, 1'b1); do_commit(); check_all("R4 col2");
    write(5'd11, 5'd5, 1'b1); do_commit(); check_all("R4 col1");
  endtask

  task automatic t_disable();
    write(5'd13, 5'd9, 1'b0);
    do_commit();
    check_all("R5 disable");
  endtask

  task automatic t_oor();
    write(5'd27, 5'd31, 1'b1);
    write(5'd31, 5'd0, 1'b1);
    do_commit();
    check_all("R6 out of range");
  endtask

  task automatic t_rows();
    write(5'd3, 5'd10, 1'b1);
    write(5'd21, 5'd18, 1'b1);
    do_commit();
    write(5'd14, 5'd2, 1'b1);
    do_commit();
    check_all("R7 other rows kept");
  endtask

  task automatic t_global_commit();
    write(5'd6, 5'd1, 1'b1);
    write(5'd23, 5'd25, 1'b1);
    write(5'd9, 5'd14, 1'b1);
    check_all("R10 before commit");
    do_commit();
    check_all("R10 one commit");
  endtask

  task automatic t_clear();
    drive_cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    model_clear(1'b0);
    check_all("R8 broadcast clear");
    write(5'd12, 5'd3, 1'b1);
    drive_cycle(1'b1, 5'd16, 5'd7, 1'b1, 1'b1, 1'b1, 1'b1);
    model_clear(1'b1);
    check_all("R8 off clear priority");
    do_commit();
    check_all("R8 first rank cleared");
    write(5'd20, 5'd30, 1'b1);
    do_commit();
    check_all("R2 after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_route();
    t_buffer();
    t_exclusive();
    t_disable();
    t_oor();
    t_rows();
    t_global_commit();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule